// File: doc/BRIEF.md
# Scatter-Gather Disk DMA Engine

This block is the bus-master data mover for one disk channel. Software builds a table of descriptors in memory, programs the table base and a completion address through a small 32-bit register file, and then sets the start bit. The engine reads each 128-bit descriptor through a single word-wide memory port. Descriptor words are stored most-significant-byte first, so the engine reverses their byte order before use. It then moves 32-bit words between the buffer named by the descriptor and a device-side stream port, in the direction chosen at start.

When it finishes the descriptor that carries the end-of-list flag, the engine writes a 16-word completion block to the completion address and drops its active flag. Software can end a transfer early with a stop request. That bit stays visible until the engine has really let go of the memory port. A memory error response halts the engine and latches an error flag, which only a stop request clears.

Top module: `sg_dma_engine`

Register map (word index on `reg_addr`): 0 control/status, 1 table base, 2 completion address, 3 device-side byte count (read only), 4 memory-side byte count (read only). All other indices read as zero.

## Requirements
- R1: A descriptor is four consecutive memory words at the current table pointer. Word 1 is the buffer address and word 3 holds the byte length in bits 15:0 and the end-of-list flag in bit 31. Words 0 and 2 are ignored. Every descriptor word is byte-reversed before use, and the next descriptor starts 16 bytes further on.
- R2: A descriptor length field of zero moves 65536 bytes.
- R3: Control bit 2 picks the direction at start. When it is 1, words are taken from the device input stream and written to memory. When it is 0, words are read from memory and sent on the device output stream. The idle stream is never used.
- R4: Writing control bit 0 while idle and error-free starts the engine, clears both byte counters and sets ACTIVE (control bit 3). After a normal finish the control register reads back only the direction bit.
- R5: After the end-of-list descriptor completes, the engine writes 16 words at the completion address and then clears ACTIVE. Word 0 is 0x0000C0DE, word 1 is the device-side byte count, word 2 is the memory-side byte count, and words 3 to 15 are zero.
- R6: Each word moved adds 4 to a byte counter, or the remaining byte count for the last, partial word of a descriptor. The device-side counter advances on the stream handshake and the memory-side counter on the memory acknowledge. While active, the two counters never differ by more than 4.
- R7: Writing control bit 1 requests a stop, and bit 1 reads as 1 until the engine has stopped. An outstanding memory access is completed first. After that the stop bit and ACTIVE clear, and no completion block is written.
- R8: A memory acknowledge with the error response sets ERROR (control bit 4), clears ACTIVE and writes no completion block. A start request is ignored while ERROR is set, and a stop request clears ERROR.
- R9: After reset, all registers read zero, and no memory request or stream handshake is offered while the engine is idle.
- R10: A memory request, with its address, is held steady until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access done (one cycle) |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| dev_in_valid | input | 1 | Device word available |
| dev_in_data | input | 32 | Device word |
| dev_in_ready | output | 1 | Engine takes the device word |
| dev_out_valid | output | 1 | Engine offers a word to the device |
| dev_out_data | output | 32 | Word for the device |
| dev_out_ready | input | 1 | Device accepts the word |

## Verification
The main path is tried with single- and two-descriptor tables in both directions. This separates correct descriptor chaining and byte reversal from a table that stops early or reads the wrong word. A second descriptor with a length that is not a multiple of four checks that partial words count only their remaining bytes. A zero length field tells a full 65536-byte transfer apart from an empty one. Stops issued while the engine waits on the device, and while a memory read is stalled, show whether the stop bit tracks the real release of the memory port. An injected error response shows the latched error flag blocking later starts until a stop clears it.

// File: rtl/sg_dma_engine.sv
module sg_dma_engine #(
  parameter int          DONE_WORDS = 16,
  parameter logic [31:0] DONE_MARK  = 32'h0000_C0DE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic [31:0] mem_rdata,
  input  logic        dev_in_valid,
  input  logic [31:0] dev_in_data,
  output logic        dev_in_ready,
  output logic        dev_out_valid,
  output logic [31:0] dev_out_data,
  input  logic        dev_out_ready
);

  localparam int IW = $clog2(DONE_WORDS);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_POP, S_MWR, S_MRD, S_PUSH, S_DONE} st_t;

  st_t          st;
  logic         dir_q, stop_q, err_q, eol_q;
  logic [31:0]  tbl_q, done_q, ptr_q, buf_q, hold_q, dcnt_q, mcnt_q;
  logic [16:0]  rem_q;
  logic [IW-1:0] idx_q;
  logic         active, ack_ok, last_beat;
  logic [2:0]   bsz;
  logic [31:0]  swp, blk_word;
  st_t          after_desc;

  assign active     = (st != S_IDLE);
  assign ack_ok     = mem_ack && !mem_err;
  assign swp        = {mem_rdata[7:0], mem_rdata[15:8], mem_rdata[23:16], mem_rdata[31:24]};
  assign bsz        = (rem_q >= 17'd4) ? 3'd4 : rem_q[2:0];
  assign last_beat  = (rem_q <= 17'd4);
  assign after_desc = eol_q ? S_DONE : S_FETCH;

  assign mem_req = (st == S_FETCH) || (st == S_MWR) || (st == S_MRD) || (st == S_DONE);
  assign mem_we  = (st == S_MWR) || (st == S_DONE);
  assign mem_addr = (st == S_FETCH) ? ptr_q  + 32'({idx_q, 2'b00}) :
                    (st == S_DONE)  ? done_q + 32'({idx_q, 2'b00}) : buf_q;
  assign mem_wdata = (st == S_DONE) ? blk_word : hold_q;

  assign dev_in_ready  = (st == S_POP)  && !stop_q;
  assign dev_out_valid = (st == S_PUSH) && !stop_q;
  assign dev_out_data  = hold_q;

  always_comb begin
    case (idx_q)
      IW'(0):  blk_word = DONE_MARK;
      IW'(1):  blk_word = dcnt_q;
      IW'(2):  blk_word = mcnt_q;
      default: blk_word = 32'd0;
    endcase
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {27'd0, err_q, active, dir_q, stop_q, 1'b0};
      3'd1:    reg_rdata = tbl_q;
      3'd2:    reg_rdata = done_q;
      3'd3:    reg_rdata = dcnt_q;
      3'd4:    reg_rdata = mcnt_q;
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      dir_q  <= 1'b0;
      stop_q <= 1'b0;
      err_q  <= 1'b0;
      eol_q  <= 1'b0;
      tbl_q  <= '0;
      done_q <= '0;
      ptr_q  <= '0;
      buf_q  <= '0;
      hold_q <= '0;
      dcnt_q <= '0;
      mcnt_q <= '0;
      rem_q  <= '0;
      idx_q  <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          3'd1: tbl_q  <= reg_wdata;
          3'd2: done_q <= reg_wdata;
          3'd0: begin
            if (reg_wdata[1]) stop_q <= 1'b1;
            else if (reg_wdata[0] && !active && !err_q) begin
              dir_q  <= reg_wdata[2];
              st     <= S_FETCH;
              ptr_q  <= tbl_q;
              idx_q  <= '0;
              dcnt_q <= '0;
              mcnt_q <= '0;
            end
          end
          default: ;
        endcase
      end

      case (st)
        S_FETCH: if (ack_ok) begin
          if (idx_q == IW'(1)) buf_q <= swp;
          if (idx_q == IW'(3)) begin
            rem_q <= (swp[15:0] == 16'd0) ? 17'h10000 : {1'b0, swp[15:0]};
            eol_q <= swp[31];
            ptr_q <= ptr_q + 32'd16;
            idx_q <= '0;
            st    <= dir_q ? S_POP : S_MRD;
          end else idx_q <= idx_q + IW'(1);
        end
        S_POP: if (dev_in_valid && dev_in_ready) begin
          hold_q <= dev_in_data;
          dcnt_q <= dcnt_q + 32'(bsz);
          st     <= S_MWR;
        end
        S_MWR: if (ack_ok) begin
          mcnt_q <= mcnt_q + 32'(bsz);
          rem_q  <= rem_q - 17'(bsz);
          buf_q  <= buf_q + 32'd4;
          st     <= last_beat ? after_desc : S_POP;
        end
        S_MRD: if (ack_ok) begin
          hold_q <= mem_rdata;
          mcnt_q <= mcnt_q + 32'(bsz);
          st     <= S_PUSH;
        end
        S_PUSH: if (dev_out_valid && dev_out_ready) begin
          dcnt_q <= dcnt_q + 32'(bsz);
          rem_q  <= rem_q - 17'(bsz);
          buf_q  <= buf_q + 32'd4;
          st     <= last_beat ? after_desc : S_MRD;
        end
        S_DONE: if (ack_ok) begin
          if (idx_q == IW'(DONE_WORDS - 1)) st <= S_IDLE;
          else idx_q <= idx_q + IW'(1);
        end
        default: ;
      endcase

      if (mem_req && mem_ack && mem_err) begin
        err_q <= 1'b1;
        st    <= S_IDLE;
      end

      if (stop_q && (!mem_req || mem_ack)) begin
        st     <= S_IDLE;
        stop_q <= 1'b0;
        err_q  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sg_dma_engine_chk.sv
module sg_dma_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic        dev_in_ready,
  input logic        dev_out_valid,
  input logic        active,
  input logic        stop_q,
  input logic        err_q,
  input logic [31:0] dcnt,
  input logic [31:0] mcnt
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R10

  AST_STOP_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q && mem_req && !mem_ack |=> stop_q); // R7

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q && !mem_req |=> !stop_q && !active); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !mem_req && !dev_in_ready && !dev_out_valid); // R9

  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !active); // R8

  AST_COUNT_RESIDUE: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (((dcnt >= mcnt) ? dcnt - mcnt : mcnt - dcnt) <= 32'd4)); // R6

endmodule

bind sg_dma_engine sg_dma_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .dev_in_ready(dev_in_ready), .dev_out_valid(dev_out_valid), .active(active),
  .stop_q(stop_q), .err_q(err_q), .dcnt(dcnt_q), .mcnt(mcnt_q)
);

// File: tb/test_sg_dma_engine.sv
module test_sg_dma_engine;

  localparam logic [31:0] TBL  = 32'h100;
  localparam logic [31:0] DONE = 32'h200;
  localparam logic [31:0] BUF0 = 32'h400;
  localparam logic [31:0] BUF1 = 32'h800;
  localparam logic [31:0] MARK = 32'h0000_C0DE;

  // {dir, descriptor count, length 0, length 1}
  localparam int NV = 4;
  localparam logic [34:0] VEC [NV] = '{
    {1'b1, 2'd1, 16'd16, 16'd0},
    {1'b0, 2'd1, 16'd12, 16'd0},
    {1'b1, 2'd2, 16'd8,  16'd6},
    {1'b0, 2'd2, 16'd4,  16'd10}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0, reg_rdata;
  logic        mem_req, mem_we, mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 32'd0;
  logic        dev_in_valid = 1'b0, dev_in_ready;
  logic [31:0] dev_in_data = 32'd0;
  logic        dev_out_valid, dev_out_ready = 1'b1;
  logic [31:0] dev_out_data;

  logic [31:0] mem [0:1023];
  logic [31:0] snk [0:63];
  int          snk_n = 0, src_i = 0, n_chk = 0, n_bad = 0;
  logic [31:0] src_base = 32'd0;
  logic        src_on = 1'b0, in_pend = 1'b0, mem_hold = 1'b0, err_en = 1'b0, finished = 1'b0;
  logic [31:0] err_addr = 32'd0;

  sg_dma_engine i_sg_dma_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
    .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready)
  );

  initial forever #4 clk = ~clk;

  function automatic logic [31:0] swap(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic int blen(input logic [15:0] l);
    return (l == 16'd0) ? 65536 : int'(l);
  endfunction

  task automatic model_step();
    if (mem_ack) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end else if (mem_req && !mem_hold) begin
      if (err_en && mem_addr == err_addr) mem_err = 1'b1;
      else if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
      mem_rdata = mem[mem_addr[11:2]];
      mem_ack = 1'b1;
    end
    if (in_pend) src_i++;
    dev_in_data  = src_base + 32'(src_i);
    dev_in_valid = src_on;
    in_pend      = dev_in_valid && dev_in_ready;
    if (dev_out_valid && dev_out_ready) begin
      if (snk_n < 64) snk[snk_n] = dev_out_data;
      snk_n++;
    end
  endtask

  initial forever begin
    @(negedge clk);
    model_step();
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #2;
    v = reg_rdata;
  endtask

  task automatic wait_idle(input int lim, input string tag);
    logic [31:0] v;
    int i;
    for (i = 0; i < lim; i++) begin
      @(posedge clk); #1;
      rd(3'd0, v);
      if (!v[3]) break;
    end
    if (i == lim) chk({tag, " engine never went idle"}, 32'd1, 32'd0);
  endtask

  task automatic clear_all();
    for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
    snk_n = 0; src_i = 0; in_pend = 1'b0; src_on = 1'b0;
  endtask

  task automatic put_desc(input int i, input logic [31:0] a, input logic [15:0] l, input logic eol);
    int w;
    w = int'(TBL[11:2]) + 4 * i;
    mem[w]     = 32'd0;
    mem[w + 1] = swap(a);
    mem[w + 2] = 32'd0;
    mem[w + 3] = swap({eol, 15'd0, l});
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    clear_all();

    // R9 reset state
    @(posedge clk); #1;
    rd(3'd0, v); chk("R9 control after reset", v, 32'd0);
    rd(3'd3, v); chk("R9 device count after reset", v, 32'd0);
    rd(3'd4, v); chk("R9 memory count after reset", v, 32'd0);
    chk("R9 no request after reset", {31'd0, mem_req}, 32'd0);

    wr(3'd1, TBL);
    wr(3'd2, DONE);

    // table-driven transfers: R1 R3 R4 R5 R6
    for (int k = 0; k < NV; k++) begin
      logic        dir;
      logic [1:0]  nd;
      logic [15:0] l0, l1;
      int          tot, w0, w1, kk;
      {dir, nd, l0, l1} = VEC[k];
      clear_all();
      src_base = 32'hA000_0000 + 32'(k << 12);
      w0 = (blen(l0) + 3) / 4;
      w1 = (nd == 2'd2) ? (blen(l1) + 3) / 4 : 0;
      tot = blen(l0) + ((nd == 2'd2) ? blen(l1) : 0);
      for (int j = 0; j < w0; j++) mem[int'(BUF0[11:2]) + j] = 32'hB000_0000 + 32'(k << 12) + 32'(j);
      for (int j = 0; j < w1; j++) mem[int'(BUF1[11:2]) + j] = 32'hB000_0100 + 32'(k << 12) + 32'(j);
      put_desc(0, BUF0, l0, nd == 2'd1);
      if (nd == 2'd2) put_desc(1, BUF1, l1, 1'b1);
      src_on = dir;
      wr(3'd0, {29'd0, dir, 2'b01});
      wait_idle(2000, "R4");
      rd(3'd0, v); chk("R4 control after finish", v, {29'd0, dir, 2'b00});
      rd(3'd3, v); chk("R6 device count", v, 32'(tot));
      rd(3'd4, v); chk("R6 memory count", v, 32'(tot));
      chk("R5 block word 0", mem[int'(DONE[11:2])], MARK);
      chk("R5 block word 1", mem[int'(DONE[11:2]) + 1], 32'(tot));
      chk("R5 block word 2", mem[int'(DONE[11:2]) + 2], 32'(tot));
      chk("R5 block word 3", mem[int'(DONE[11:2]) + 3], 32'd0);
      kk = 0;
      if (dir) begin
        chk("R3 nothing sent to device", 32'(snk_n), 32'd0);
        for (int j = 0; j < w0; j++) begin
          chk("R1 R3 memory word desc 0", mem[int'(BUF0[11:2]) + j], src_base + 32'(kk)); kk++;
        end
        for (int j = 0; j < w1; j++) begin
          chk("R1 R3 memory word desc 1", mem[int'(BUF1[11:2]) + j], src_base + 32'(kk)); kk++;
        end
      end else begin
        chk("R3 nothing taken from device", 32'(src_i), 32'd0);
        chk("R3 device word total", 32'(snk_n), 32'(w0 + w1));
        for (int j = 0; j < w0; j++) begin
          chk("R1 R3 device word desc 0", snk[kk], 32'hB000_0000 + 32'(k << 12) + 32'(j)); kk++;
        end
        for (int j = 0; j < w1; j++) begin
          chk("R1 R3 device word desc 1", snk[kk], 32'hB000_0100 + 32'(k << 12) + 32'(j)); kk++;
        end
      end
    end

    // R2 zero length means 65536 bytes
    clear_all();
    src_base = 32'hC000_0000;
    put_desc(0, BUF0, 16'd0, 1'b1);
    src_on = 1'b1;
    wr(3'd0, 32'h5);
    wait_idle(100000, "R2");
    rd(3'd3, v); chk("R2 device count 65536", v, 32'd65536);
    rd(3'd4, v); chk("R2 memory count 65536", v, 32'd65536);
    chk("R2 block reports 65536", mem[int'(DONE[11:2]) + 1], 32'd65536);

    // R7 stop while waiting on the device
    clear_all();
    put_desc(0, BUF0, 16'd16, 1'b1);
    dev_out_ready = 1'b0;
    wr(3'd0, 32'h1);
    repeat (30) @(posedge clk);
    #1 rd(3'd0, v); chk("R7 active while stalled", v, 32'h8);
    wr(3'd0, 32'h2);
    rd(3'd0, v); chk("R7 stop bit pending", v, 32'hA);
    @(posedge clk); #1;
    rd(3'd0, v); chk("R7 stop self-clears", v, 32'd0);
    rd(3'd3, v); chk("R7 no device word counted", v, 32'd0);
    rd(3'd4, v); chk("R7 one memory word counted", v, 32'd4);
    chk("R7 no completion block", mem[int'(DONE[11:2])], 32'd0);
    dev_out_ready = 1'b1;

    // R7 stop with a stalled memory read
    clear_all();
    put_desc(0, BUF0, 16'd8, 1'b1);
    mem_hold = 1'b1;
    wr(3'd0, 32'h1);
    wr(3'd0, 32'h2);
    repeat (5) @(posedge clk);
    #1 rd(3'd0, v); chk("R7 stop held during stalled access", v[1], 1'b1);
    mem_hold = 1'b0;
    repeat (3) @(posedge clk);
    #1 rd(3'd0, v); chk("R7 stop clears after access", v, 32'd0);
    chk("R7 no completion block after stall", mem[int'(DONE[11:2])], 32'd0);

    // R8 error response
    clear_all();
    put_desc(0, BUF0, 16'd8, 1'b1);
    err_addr = BUF0; err_en = 1'b1;
    wr(3'd0, 32'h1);
    wait_idle(200, "R8");
    rd(3'd0, v); chk("R8 error set, not active", v, 32'h10);
    chk("R8 no completion block", mem[int'(DONE[11:2])], 32'd0);
    chk("R8 nothing sent to device", 32'(snk_n), 32'd0);
    wr(3'd0, 32'h1);
    @(posedge clk); #1;
    rd(3'd0, v); chk("R8 start ignored while error", v, 32'h10);
    chk("R8 no request after ignored start", {31'd0, mem_req}, 32'd0);
    err_en = 1'b0;
    wr(3'd0, 32'h2);
    @(posedge clk); #1;
    rd(3'd0, v); chk("R8 stop clears error", v, 32'd0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule